// File: doc/BRIEF.md
# Frame-Sync Read Timing Controller

This block produces the read timing for a multi-frame video store. Output video is aligned to an external reference pulse and shifted by a signed phase offset. It counts samples from the reference pulse and fires an internal output sync when that count reaches the phase offset. At each output sync it restarts its output line and sample counters. It also picks the stored frame to read, so that the total delay from input to output is never less than the requested video delay and never a full frame more than it. The memory array itself lies outside the block: the block only supplies the frame index, line and sample that a read port needs.

The phase offset is entered as signed frames, lines and samples. It is clamped to a guard band inside one frame, then folded onto a single frame, so a large positive offset behaves like a small negative one. The video delay is entered as whole frames plus lines, with a floor of two lines. A setting that the store cannot hold is refused and flagged, and the last accepted setting stays in force. When reference pulses stop arriving, the output sync free-runs from the input frame timing, delayed by exactly the video delay.

Top module: `fsd_ctrl`

## Requirements
- R1: With reference present, `rd_sof` is high in the cycle after a clock edge at which the reference position equals the phase offset. The reference position is 0 at an edge where `ref_sync` is high and counts up by one per clock, modulo FRAME = SPL*LPF.
- R2: The phase offset is ph_frames*FRAME + ph_lines*SPL + ph_samples, with all three fields signed two's complement. A negative result has FRAME added to it, so the offset lies in 0..FRAME-1.
- R3: Before that fold, the signed phase sum is clamped to the range -(FRAME-GUARD) .. +(FRAME-GUARD).
- R4: At each output sync, `rd_frame` = (cur - vf - (ipos < vrem ? 1 : 0)) mod NUM_FRAMES. Here cur counts `in_sof` pulses since reset, including one at that edge. ipos is the input position, 0 at an `in_sof` edge and counting up. vf is the accepted delay in frames, and vrem is the accepted delay lines times SPL.
- R5: When vd_frames is 0 and vd_lines is below 2, the delay used is 2 lines (vrem = 2*SPL).
- R6: A delay setting with vd_frames > NUM_FRAMES-2, or with vd_lines >= LPF, raises `vd_reject` from the next cycle on and leaves the previously accepted delay in use.
- R7: `rd_sample` and `rd_line` are 0 in the cycle `rd_sof` is high. `rd_sample` then counts 0..SPL-1; each time it wraps, `rd_line` advances, wrapping at LPF. `rd_frame` changes only together with `rd_sof`.
- R8: `ref_present` is 1 in the cycle after any `ref_sync` pulse. It drops to 0 once TIMEOUT_FRAMES*FRAME cycles have passed without a pulse.
- R9: Without reference, the output sync fires at the edge where ipos equals vrem, and `rd_frame` = (cur - vf) mod NUM_FRAMES.
- R10: During reset, all outputs are 0, and the accepted delay is 0 frames and 2 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ref_sync | input | 1 | Reference frame start pulse |
| in_sof | input | 1 | Input frame start pulse; a new frame starts being written |
| ph_frames | input | 2 | Signed phase offset, frames part |
| ph_lines | input | LW+1 | Signed phase offset, lines part |
| ph_samples | input | SW+1 | Signed phase offset, samples part |
| vd_frames | input | FI_W | Video delay, whole frames |
| vd_lines | input | LW | Video delay, extra lines |
| rd_frame | output | FI_W | Store frame index to read |
| rd_line | output | LW | Read line within the frame |
| rd_sample | output | SW | Read sample within the line |
| rd_sof | output | 1 | Output frame start (internal sync, registered) |
| ref_present | output | 1 | Reference pulses are being received |
| vd_reject | output | 1 | Current delay setting refused |

## Verification
The hardest case to reach is the frame selection when the output sync falls just before or just after the point in the input frame that equals the fractional delay. This boundary decides whether one extra frame of age is added. The stimulus runs the reference and the input frame starts at independent random phases, together with random offsets and delays. Over many frames this places the output sync on both sides of that point. The bench also drives a free-running phase where the sync sits exactly on it. Refused delay settings are applied between valid ones, so that the held setting shows up in the chosen frame index.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic {SRC_FREE = 1'b0, SRC_REF = 1'b1} sync_src_e;
  localparam int MIN_DELAY_LINES = 2;
endpackage

// File: rtl/fsd_pos_cnt.sv
module fsd_pos_cnt #(
  parameter int LEN = 640,
  localparam int W = $clog2(LEN)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] pos
);
  logic [W-1:0] q;

  assign pos = start ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (pos == W'(LEN - 1)) ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/fsd_phase_calc.sv
module fsd_phase_calc #(
  parameter int SPL   = 2200,
  parameter int LPF   = 1125,
  parameter int GUARD = 1100,
  localparam int FRAME = SPL * LPF,
  localparam int POS_W = $clog2(FRAME),
  localparam int LW    = $clog2(LPF),
  localparam int SW    = $clog2(SPL),
  localparam int PD_W  = POS_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic signed [1:0] ph_frames,
  input  logic signed [LW:0] ph_lines,
  input  logic signed [SW:0] ph_samples,
  output logic [POS_W-1:0]  offset
);
  localparam logic signed [PD_W-1:0] FRAME_S = PD_W'(FRAME);
  localparam logic signed [PD_W-1:0] SPL_S   = PD_W'(SPL);
  localparam logic signed [PD_W-1:0] LIM_S   = PD_W'(FRAME - GUARD);

  logic signed [PD_W-1:0] f_x, l_x, s_x, total, clamped, folded;

  always_comb begin
    f_x   = PD_W'(ph_frames);
    l_x   = PD_W'(ph_lines);
    s_x   = PD_W'(ph_samples);
    total = f_x * FRAME_S + l_x * SPL_S + s_x;
    if (total > LIM_S)       clamped = LIM_S;
    else if (total < -LIM_S) clamped = -LIM_S;
    else                     clamped = total;
    folded = (clamped < 0) ? clamped + FRAME_S : clamped;
  end

  always_ff @(posedge clk) begin
    if (rst) offset <= '0;
    else     offset <= POS_W'(folded);
  end
endmodule

// File: rtl/fsd_delay_sel.sv
module fsd_delay_sel
  import fsd_pkg::*;
#(
  parameter int SPL        = 2200,
  parameter int LPF        = 1125,
  parameter int NUM_FRAMES = 8,
  localparam int FRAME = SPL * LPF,
  localparam int POS_W = $clog2(FRAME),
  localparam int LW    = $clog2(LPF),
  localparam int FI_W  = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FI_W-1:0]  vd_frames,
  input  logic [LW-1:0]    vd_lines,
  output logic [FI_W-1:0]  acc_frames,
  output logic [POS_W-1:0] acc_rem,
  output logic             reject
);
  logic [LW-1:0]    lines_eff;
  logic [POS_W-1:0] rem_c;
  logic             valid;

  always_comb begin
    lines_eff = vd_lines;
    if (vd_frames == '0 && vd_lines < LW'(MIN_DELAY_LINES))
      lines_eff = LW'(MIN_DELAY_LINES);
    rem_c = POS_W'(lines_eff) * POS_W'(SPL);
    valid = (int'(vd_frames) <= NUM_FRAMES - 2) && (int'(vd_lines) < LPF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_frames <= '0;
      acc_rem    <= POS_W'(MIN_DELAY_LINES * SPL);
      reject     <= 1'b0;
    end else begin
      reject <= !valid;
      if (valid) begin
        acc_frames <= vd_frames;
        acc_rem    <= rem_c;
      end
    end
  end
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
#(
  parameter int SPL            = 2200,
  parameter int LPF            = 1125,
  parameter int NUM_FRAMES     = 8,
  parameter int GUARD          = 1100,
  parameter int TIMEOUT_FRAMES = 2,
  localparam int FRAME   = SPL * LPF,
  localparam int POS_W   = $clog2(FRAME),
  localparam int LW      = $clog2(LPF),
  localparam int SW      = $clog2(SPL),
  localparam int FI_W    = $clog2(NUM_FRAMES),
  localparam int TIMEOUT = TIMEOUT_FRAMES * FRAME,
  localparam int GAP_W   = $clog2(TIMEOUT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_sync,
  input  logic               in_sof,
  input  logic signed [1:0]  ph_frames,
  input  logic signed [LW:0] ph_lines,
  input  logic signed [SW:0] ph_samples,
  input  logic [FI_W-1:0]    vd_frames,
  input  logic [LW-1:0]      vd_lines,
  output logic [FI_W-1:0]    rd_frame,
  output logic [LW-1:0]      rd_line,
  output logic [SW-1:0]      rd_sample,
  output logic               rd_sof,
  output logic               ref_present,
  output logic               vd_reject
);
  logic [POS_W-1:0] ref_pos, in_pos, offset, acc_rem;
  logic [FI_W-1:0]  acc_frames, wr_idx, cur_idx, back;
  logic [GAP_W-1:0] gap;
  logic             isync;
  sync_src_e        src;

  fsd_pos_cnt #(.LEN(FRAME)) u_ref_pos (
    .clk(clk), .rst(rst), .start(ref_sync), .pos(ref_pos)
  );

  fsd_pos_cnt #(.LEN(FRAME)) u_in_pos (
    .clk(clk), .rst(rst), .start(in_sof), .pos(in_pos)
  );

  fsd_phase_calc #(.SPL(SPL), .LPF(LPF), .GUARD(GUARD)) u_phase (
    .clk(clk), .rst(rst), .ph_frames(ph_frames), .ph_lines(ph_lines),
    .ph_samples(ph_samples), .offset(offset)
  );

  fsd_delay_sel #(.SPL(SPL), .LPF(LPF), .NUM_FRAMES(NUM_FRAMES)) u_delay (
    .clk(clk), .rst(rst), .vd_frames(vd_frames), .vd_lines(vd_lines),
    .acc_frames(acc_frames), .acc_rem(acc_rem), .reject(vd_reject)
  );

  // reference presence watchdog
  always_ff @(posedge clk) begin
    if (rst) begin
      gap         <= '0;
      ref_present <= 1'b0;
    end else if (ref_sync) begin
      gap         <= '0;
      ref_present <= 1'b1;
    end else begin
      if (gap != GAP_W'(TIMEOUT)) gap <= gap + 1'b1;
      if (gap == GAP_W'(TIMEOUT)) ref_present <= 1'b0;
    end
  end

  // write-side frame index
  always_ff @(posedge clk) begin
    if (rst)         wr_idx <= '0;
    else if (in_sof) wr_idx <= wr_idx + 1'b1;
  end

  always_comb begin
    src     = ref_present ? SRC_REF : SRC_FREE;
    cur_idx = wr_idx + FI_W'(in_sof);
    back    = acc_frames + FI_W'(in_pos < acc_rem);
    isync   = (src == SRC_REF) ? (ref_pos == offset) : (in_pos == acc_rem);
  end

  // read-side timing
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_frame  <= '0;
      rd_line   <= '0;
      rd_sample <= '0;
      rd_sof    <= 1'b0;
    end else if (isync) begin
      rd_frame  <= cur_idx - back;
      rd_line   <= '0;
      rd_sample <= '0;
      rd_sof    <= 1'b1;
    end else begin
      rd_sof <= 1'b0;
      if (rd_sample == SW'(SPL - 1)) begin
        rd_sample <= '0;
        rd_line   <= (rd_line == LW'(LPF - 1)) ? '0 : rd_line + 1'b1;
      end else begin
        rd_sample <= rd_sample + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsd_ctrl_chk.sv
module fsd_ctrl_chk #(
  parameter int SPL        = 2200,
  parameter int LPF        = 1125,
  parameter int NUM_FRAMES = 8,
  localparam int LW   = $clog2(LPF),
  localparam int SW   = $clog2(SPL),
  localparam int FI_W = $clog2(NUM_FRAMES)
) (
  input logic            clk,
  input logic            rst,
  input logic            ref_sync,
  input logic [FI_W-1:0] vd_frames,
  input logic [FI_W-1:0] rd_frame,
  input logic [LW-1:0]   rd_line,
  input logic [SW-1:0]   rd_sample,
  input logic            rd_sof,
  input logic            ref_present,
  input logic            vd_reject
);
  p_sof_origin_r7: assert property (@(posedge clk) disable iff (rst)
    rd_sof |-> (rd_line == '0 && rd_sample == '0));

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_sof |-> $stable(rd_frame));

  p_sample_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !rd_sof && $past(rd_sample) != SW'(SPL - 1))
      |-> rd_sample == SW'($past(rd_sample) + 1'b1));

  p_present_r8: assert property (@(posedge clk) disable iff (rst)
    ref_sync |=> ref_present);

  p_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(vd_frames) > NUM_FRAMES - 2) |=> vd_reject);
endmodule

bind fsd_ctrl fsd_ctrl_chk #(.SPL(SPL), .LPF(LPF), .NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk(clk), .rst(rst), .ref_sync(ref_sync), .vd_frames(vd_frames),
  .rd_frame(rd_frame), .rd_line(rd_line), .rd_sample(rd_sample),
  .rd_sof(rd_sof), .ref_present(ref_present), .vd_reject(vd_reject)
);

// File: tb/fsd_ctrl_test.sv
`timescale 1ns/1ps
module fsd_ctrl_test;
  localparam int SPL = 32, LPF = 20, NF = 8, GUARD = 20, TOF = 2;
  localparam int FR = SPL * LPF, TMO = TOF * FR;
  localparam int LW = $clog2(LPF), SW = $clog2(SPL);

  logic clk = 1'b0, rst = 1'b1, ref_sync = 1'b0, in_sof = 1'b0;
  logic signed [1:0]  ph_frames = '0;
  logic signed [LW:0] ph_lines = '0;
  logic signed [SW:0] ph_samples = '0;
  logic [2:0]    vd_frames = '0;
  logic [LW-1:0] vd_lines = LW'(2);
  logic [2:0]    rd_frame;
  logic [LW-1:0] rd_line;
  logic [SW-1:0] rd_sample;
  logic rd_sof, ref_present, vd_reject;

  fsd_ctrl #(.SPL(SPL), .LPF(LPF), .NUM_FRAMES(NF), .GUARD(GUARD),
             .TIMEOUT_FRAMES(TOF)) uut (
    .clk(clk), .rst(rst), .ref_sync(ref_sync), .in_sof(in_sof),
    .ph_frames(ph_frames), .ph_lines(ph_lines), .ph_samples(ph_samples),
    .vd_frames(vd_frames), .vd_lines(vd_lines), .rd_frame(rd_frame),
    .rd_line(rd_line), .rd_sample(rd_sample), .rd_sof(rd_sof),
    .ref_present(ref_present), .vd_reject(vd_reject)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit running = 0, check_en = 0, send_ref = 0, model_ref = 1, done = 0;
  int ref_ph = 0, in_ph = 0;
  string round_tag = "R1", frame_tag = "R4";

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_offset(int pf, int pl, int ps);
    int t, lim;
    t = pf * FR + pl * SPL + ps;
    lim = FR - GUARD;
    if (t > lim) t = lim;
    if (t < -lim) t = -lim;
    if (t < 0) t += FR;
    return t;
  endfunction

  function automatic bit vd_ok(int vf, int vl);
    return (vf <= NF - 2) && (vl < LPF);
  endfunction

  function automatic int vd_rem(int vf, int vl);
    return ((vf == 0 && vl < 2) ? 2 : vl) * SPL;
  endfunction

  // model state, written only here
  int cyc = 0, n_in = 0, k = 0, pend_frame = 0, acc_vf = 0, acc_vrem = 2 * SPL;
  bit pend_sync = 0;

  always @(negedge clk) begin
    int rpos, ipos, back;
    if (running) begin
      if (check_en) begin
        check(round_tag, "rd_sof", int'(rd_sof), int'(pend_sync));
        if (pend_sync) check(frame_tag, "rd_frame", int'(rd_frame), pend_frame);
        check("R7", "rd_sample", int'(rd_sample), k % SPL);
        check("R7", "rd_line", int'(rd_line), (k / SPL) % LPF);
      end
      cyc++;
      rpos = (cyc + FR - ref_ph) % FR;
      ipos = (cyc + FR - in_ph) % FR;
      ref_sync = send_ref && (rpos == 0);
      in_sof = (ipos == 0);
      if (in_sof) n_in++;
      if (model_ref)
        pend_sync = (rpos == exp_offset(int'(ph_frames), int'(ph_lines), int'(ph_samples)));
      else
        pend_sync = (ipos == acc_vrem);
      back = acc_vf + ((ipos < acc_vrem) ? 1 : 0);
      pend_frame = (n_in - back) & (NF - 1);
      k = pend_sync ? 0 : k + 1;
      if (vd_ok(int'(vd_frames), int'(vd_lines))) begin
        acc_vf = int'(vd_frames);
        acc_vrem = vd_rem(int'(vd_frames), int'(vd_lines));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic round(input string rt, input string ft, input int settle, input int len);
    check_en = 0;
    round_tag = rt;
    frame_tag = ft;
    wait_cyc(settle);
    check_en = 1;
    wait_cyc(len);
    check_en = 0;
  endtask

  task automatic set_phase(input int pf, input int pl, input int ps);
    ph_frames = 2'(pf);
    ph_lines = (LW+1)'(pl);
    ph_samples = (SW+1)'(ps);
  endtask

  task automatic set_delay(input int vf, input int vl);
    vd_frames = 3'(vf);
    vd_lines = LW'(vl);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    wait_cyc(5);
    // R10: reset state
    check("R10", "rd_frame", int'(rd_frame), 0);
    check("R10", "rd_line", int'(rd_line), 0);
    check("R10", "rd_sample", int'(rd_sample), 0);
    check("R10", "rd_sof", int'(rd_sof), 0);
    check("R10", "ref_present", int'(ref_present), 0);
    check("R10", "vd_reject", int'(vd_reject), 0);
    rst = 0;
    running = 1;

    send_ref = 1; ref_ph = 100; in_ph = 300; model_ref = 1;
    round("R1", "R4", 3 * FR, 2 * FR);
    check("R8", "ref_present", int'(ref_present), 1);

    // R2: signed composition and frame fold
    set_phase(0, 0, -5);  round("R2", "R4", 2 * FR, 2 * FR);
    set_phase(1, -1, 0);  round("R2", "R4", 2 * FR, 2 * FR);
    set_phase(-1, 3, 7);  round("R2", "R4", 2 * FR, 2 * FR);

    // R3: clamp to the guard band
    set_phase(1, 0, 0);   round("R3", "R4", 2 * FR, 2 * FR);
    set_phase(-1, -5, 0); round("R3", "R4", 2 * FR, 2 * FR);
    set_phase(1, 19, 31); round("R3", "R4", 2 * FR, 2 * FR);

    // R5: two-line floor
    set_phase(0, 2, 0);
    set_delay(0, 0); in_ph = 120; round("R1", "R5", 2 * FR, 2 * FR);
    set_delay(0, 1); round("R1", "R5", 2 * FR, 2 * FR);

    // R6: refused settings keep the previous delay
    set_delay(3, 5); round("R1", "R4", 2 * FR, FR);
    check("R6", "vd_reject", int'(vd_reject), 0);
    set_delay(7, 5); wait_cyc(3);
    check("R6", "vd_reject", int'(vd_reject), 1);
    round("R1", "R6", 2 * FR, 2 * FR);
    set_delay(2, LPF); wait_cyc(3);
    check("R6", "vd_reject", int'(vd_reject), 1);
    round("R1", "R6", 2 * FR, 2 * FR);
    set_delay(2, 4); wait_cyc(3);
    check("R6", "vd_reject", int'(vd_reject), 0);

    // random rounds
    for (int i = 0; i < 12; i++) begin
      set_phase($urandom_range(0, 2) - 1, $urandom_range(0, 2 * LPF) - LPF,
                $urandom_range(0, 62) - 31);
      set_delay($urandom_range(0, NF - 2), $urandom_range(0, LPF - 1));
      ref_ph = $urandom_range(0, FR - 1);
      in_ph = $urandom_range(0, FR - 1);
      round("R1", "R4", 3 * FR, 2 * FR);
    end

    // R8/R9: loss of reference, free-running
    check_en = 0;
    send_ref = 0;
    wait_cyc(TMO + 20);
    check("R8", "ref_present", int'(ref_present), 0);
    model_ref = 0;
    set_delay(0, 2); round("R9", "R4", FR, 2 * FR);
    set_delay(4, 7); in_ph = 50; round("R9", "R4", 2 * FR, 2 * FR);

    // reference returns
    set_delay(1, 9);
    send_ref = 1; ref_ph = 400;
    wait_cyc(FR + 5);
    check("R8", "ref_present", int'(ref_present), 1);
    model_ref = 1;
    round("R1", "R4", 2 * FR, 2 * FR);

    finish_run();
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule